// File: doc/BRIEF.md
# Windowed Register File Controller

This block holds the integer register state of a processor core that passes procedure arguments through overlapping register windows. Thirty-two architectural registers, reached by a 5-bit specifier, are kept as four groups of eight: a shared global group and per-call local, input and output groups. A save command opens a new window. The caller's inputs are parked in a small on-chip frame stack, the caller's outputs become the callee's inputs, and the locals start at zero. A restore command reverses this.

The on-chip frame stack has a fixed number of slots. A save that finds every slot occupied first writes the oldest parked frame to an external memory, one register per request/acknowledge beat. A restore that finds the stack empty first reads the most recently spilled frame back. While such a transfer runs, a busy output is high and the block drops new commands and register writes. Shallow call chains never touch memory. A restore with nothing left anywhere sets a sticky underflow flag.

Top module: `windowed_regfile`

## Requirements
- R1: After reset every register reads zero, and busy, underflow and the memory request are all low.
- R2: Specifiers 0-7 select the global group, 8-15 the outputs, 16-23 the locals and 24-31 the inputs, with the register index in bits 2:0. Both read ports are combinational and independent. A write is visible on the read ports from the next cycle.
- R3: Global register 0 ignores writes and always reads zero.
- R4: A save accepted with a free stack slot copies the outputs into the inputs, clears the locals, and leaves the outputs and the globals unchanged. The result is visible from the next cycle.
- R5: A restore accepted with a non-empty stack copies the inputs into the outputs, loads the inputs with the most recently parked frame, and clears the locals. The globals are unchanged.
- R6: Any sequence of saves and restores that keeps no more than 4 frames parked raises no memory request.
- R7: A save accepted with all 4 slots full writes the oldest parked frame to memory in 8 beats. Beat k writes input register k of that frame at address P*8+k, where P is the number of frames already in memory. P then increments, and the save takes effect on the edge of the last acknowledge.
- R8: A restore accepted with an empty stack and P>0 reads 8 beats from addresses (P-1)*8+k into input register k of the new window. The restore takes effect one cycle after the last acknowledge, and P decrements.
- R9: Busy is high from the cycle after a spill or fill is accepted until the window move completes. Commands and register writes presented while busy are dropped.
- R10: A restore accepted with an empty stack and P=0 sets the underflow flag, which stays set until reset. No register changes.
- R11: When save and restore are presented together, the save is performed. A register write presented in the same cycle as an accepted command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| save_i | input | 1 | Open a new window |
| restore_i | input | 1 | Return to the previous window |
| rd_a_spec_i | input | 5 | Read port A specifier |
| rd_a_data_o | output | DATA_W | Read port A data |
| rd_b_spec_i | input | 5 | Read port B specifier |
| rd_b_data_o | output | DATA_W | Read port B data |
| wr_en_i | input | 1 | Register write enable |
| wr_spec_i | input | 5 | Write specifier |
| wr_data_i | input | DATA_W | Write data |
| busy_o | output | 1 | Spill or fill in progress |
| underflow_o | output | 1 | Sticky restore-underflow flag |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Beat is a write (spill) |
| mem_addr_o | output | MEM_ADDR_W | Beat word address |
| mem_wdata_o | output | DATA_W | Spill data |
| mem_rdata_i | input | DATA_W | Fill data |
| mem_ack_i | input | 1 | Beat acknowledge |

## Verification
Register reads are combinational. A write or a move without memory traffic is therefore visible at the first falling edge after the accepting clock edge, and every full register scan is made there. With the bench memory acknowledging on alternate cycles, a spill holds busy for exactly 15 sampled cycles and a fill for 16. The bench counts busy on each falling edge and expects it low on the next one. The memory image written by spills is compared against the reference model only after busy falls. The traffic check counts request cycles over the shallow sequence.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
   localparam int SPEC_W   = 5;
   localparam int IDX_W    = 3;
   localparam int GRP_SIZE = 8;

   typedef enum logic [1:0] {
      GRP_GLOBAL = 2'd0,
      GRP_OUT    = 2'd1,
      GRP_LOCAL  = 2'd2,
      GRP_IN     = 2'd3
   } grp_e;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_SPILL,
      SEQ_FILL,
      SEQ_FILL_END
   } seq_e;

   function automatic grp_e spec_group(input logic [SPEC_W-1:0] spec);
      return grp_e'(spec[SPEC_W-1:IDX_W]);
   endfunction
endpackage

// File: rtl/wrf_read_port.sv
module wrf_read_port
   import wrf_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [SPEC_W-1:0]                  spec_i,
   input  logic [GRP_SIZE-1:0][DATA_W-1:0]    glob_i,
   input  logic [GRP_SIZE-1:0][DATA_W-1:0]    outs_i,
   input  logic [GRP_SIZE-1:0][DATA_W-1:0]    locs_i,
   input  logic [GRP_SIZE-1:0][DATA_W-1:0]    ins_i,
   output logic [DATA_W-1:0]                  data_o
);
   logic [IDX_W-1:0] idx;
   assign idx = spec_i[IDX_W-1:0];

   always_comb begin
      unique case (spec_group(spec_i))
         GRP_GLOBAL: data_o = glob_i[idx];
         GRP_OUT:    data_o = outs_i[idx];
         GRP_LOCAL:  data_o = locs_i[idx];
         default:    data_o = ins_i[idx];
      endcase
   end
endmodule

// File: rtl/wrf_frame_stack.sv
module wrf_frame_stack
   import wrf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               push_i,
   input  logic                               pop_i,
   input  logic                               shift_push_i,
   input  logic                               fill_we_i,
   input  logic [IDX_W-1:0]                   fill_idx_i,
   input  logic [DATA_W-1:0]                  fill_data_i,
   input  logic [GRP_SIZE-1:0][DATA_W-1:0]    push_frame_i,
   output logic [GRP_SIZE-1:0][DATA_W-1:0]    top_frame_o,
   output logic [GRP_SIZE-1:0][DATA_W-1:0]    bottom_frame_o,
   output logic                               full_o,
   output logic                               empty_o
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [GRP_SIZE-1:0][DATA_W-1:0] slot_q [DEPTH];
   logic [CNT_W-1:0]                count_q;

   assign full_o         = (count_q == CNT_W'(DEPTH));
   assign empty_o        = (count_q == '0);
   assign bottom_frame_o = slot_q[0];

   always_comb begin
      top_frame_o = slot_q[0];
      for (int i = 0; i < DEPTH; i++)
         if (count_q == CNT_W'(i + 1)) top_frame_o = slot_q[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      end else begin
         if (push_i) begin
            for (int i = 0; i < DEPTH; i++)
               if (count_q == CNT_W'(i)) slot_q[i] <= push_frame_i;
            count_q <= count_q + 1'b1;
         end else if (pop_i) begin
            count_q <= count_q - 1'b1;
         end else if (shift_push_i) begin
            for (int i = 0; i < DEPTH - 1; i++) slot_q[i] <= slot_q[i+1];
            slot_q[DEPTH-1] <= push_frame_i;
         end
         if (fill_we_i) slot_q[0][fill_idx_i] <= fill_data_i;
      end
   end

   // R6
   stack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH));
   // R7
   no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);
   // R5
   no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |=> (count_q == $past(count_q) - 1'b1));
endmodule

// File: rtl/wrf_mem_seq.sv
module wrf_mem_seq
   import wrf_pkg::*;
#(
   parameter int MEM_ADDR_W = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    spill_start_i,
   input  logic                    fill_start_i,
   input  logic                    mem_ack_i,
   output logic                    busy_o,
   output logic                    mem_req_o,
   output logic                    mem_we_o,
   output logic [MEM_ADDR_W-1:0]   mem_addr_o,
   output logic [IDX_W-1:0]        beat_o,
   output logic                    spill_done_o,
   output logic                    fill_we_o,
   output logic                    fill_done_o,
   output logic                    depth_zero_o
);
   localparam int FP_W = MEM_ADDR_W - IDX_W;
   localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(GRP_SIZE - 1);

   seq_e             state_q;
   logic [IDX_W-1:0] beat_q;
   logic [FP_W-1:0]  fp_q;
   logic [FP_W-1:0]  frame_sel;

   assign busy_o       = (state_q != SEQ_IDLE);
   assign mem_req_o    = (state_q == SEQ_SPILL) || (state_q == SEQ_FILL);
   assign mem_we_o     = (state_q == SEQ_SPILL);
   assign frame_sel    = (state_q == SEQ_FILL) ? fp_q - 1'b1 : fp_q;
   assign mem_addr_o   = {frame_sel, beat_q};
   assign beat_o       = beat_q;
   assign spill_done_o = (state_q == SEQ_SPILL) && mem_ack_i && (beat_q == LAST_BEAT);
   assign fill_we_o    = (state_q == SEQ_FILL) && mem_ack_i;
   assign fill_done_o  = (state_q == SEQ_FILL_END);
   assign depth_zero_o = (fp_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         beat_q  <= '0;
         fp_q    <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               beat_q <= '0;
               if (spill_start_i)     state_q <= SEQ_SPILL;
               else if (fill_start_i) state_q <= SEQ_FILL;
            end
            SEQ_SPILL: if (mem_ack_i) begin
               beat_q <= beat_q + 1'b1;
               if (beat_q == LAST_BEAT) begin
                  state_q <= SEQ_IDLE;
                  fp_q    <= fp_q + 1'b1;
               end
            end
            SEQ_FILL: if (mem_ack_i) begin
               beat_q <= beat_q + 1'b1;
               if (beat_q == LAST_BEAT) state_q <= SEQ_FILL_END;
            end
            default: begin
               state_q <= SEQ_IDLE;
               fp_q    <= fp_q - 1'b1;
            end
         endcase
      end
   end

   // R7
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
   // R7
   spill_fp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spill_done_o |=> (fp_q == $past(fp_q) + 1'b1));
   // R8
   fill_needs_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_start_i |-> !depth_zero_o);
   // R9
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> busy_o);
endmodule

// File: rtl/windowed_regfile.sv
module windowed_regfile
   import wrf_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int FRAME_SLOTS = 4,
   parameter int MEM_ADDR_W  = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  save_i,
   input  logic                  restore_i,
   input  logic [4:0]            rd_a_spec_i,
   output logic [DATA_W-1:0]     rd_a_data_o,
   input  logic [4:0]            rd_b_spec_i,
   output logic [DATA_W-1:0]     rd_b_data_o,
   input  logic                  wr_en_i,
   input  logic [4:0]            wr_spec_i,
   input  logic [DATA_W-1:0]     wr_data_i,
   output logic                  busy_o,
   output logic                  underflow_o,
   output logic                  mem_req_o,
   output logic                  mem_we_o,
   output logic [MEM_ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0]     mem_wdata_o,
   input  logic [DATA_W-1:0]     mem_rdata_i,
   input  logic                  mem_ack_i
);
   localparam int N_RD = 2;

   if (FRAME_SLOTS < 1) begin : g_bad_slots
      $error("FRAME_SLOTS must be at least 1");
   end
   if (MEM_ADDR_W <= IDX_W) begin : g_bad_addr
      $error("MEM_ADDR_W must exceed the register index width");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic [GRP_SIZE-1:0][DATA_W-1:0] glob_q, loc_q, in_q, out_q;
   logic [GRP_SIZE-1:0][DATA_W-1:0] top_frame, bottom_frame, rest_frame;
   logic underflow_q;
   logic stk_full, stk_empty;
   logic acc_save, acc_rest, cmd_seen, wr_ok;
   logic do_save, do_rest;
   logic spill_done, fill_we, fill_done, depth_zero;
   logic [IDX_W-1:0] beat;
   logic [IDX_W-1:0] wr_idx;

   assign cmd_seen = (save_i || restore_i) && !busy_o;
   assign acc_save = save_i && !busy_o;
   assign acc_rest = restore_i && !save_i && !busy_o;
   assign wr_ok    = wr_en_i && !busy_o && !cmd_seen;
   assign wr_idx   = wr_spec_i[IDX_W-1:0];
   assign do_save  = (acc_save && !stk_full) || spill_done;
   assign do_rest  = (acc_rest && !stk_empty) || fill_done;
   assign rest_frame  = fill_done ? bottom_frame : top_frame;
   assign mem_wdata_o = bottom_frame[beat];
   assign underflow_o = underflow_q;

   wrf_frame_stack #(.DATA_W(DATA_W), .DEPTH(FRAME_SLOTS)) u_stack (
      .clk           (clk),
      .rst_n         (rst_n),
      .push_i        (acc_save && !stk_full),
      .pop_i         (acc_rest && !stk_empty),
      .shift_push_i  (spill_done),
      .fill_we_i     (fill_we),
      .fill_idx_i    (beat),
      .fill_data_i   (mem_rdata_i),
      .push_frame_i  (in_q),
      .top_frame_o   (top_frame),
      .bottom_frame_o(bottom_frame),
      .full_o        (stk_full),
      .empty_o       (stk_empty)
   );

   wrf_mem_seq #(.MEM_ADDR_W(MEM_ADDR_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .spill_start_i(acc_save && stk_full),
      .fill_start_i (acc_rest && stk_empty && !depth_zero),
      .mem_ack_i    (mem_ack_i),
      .busy_o       (busy_o),
      .mem_req_o    (mem_req_o),
      .mem_we_o     (mem_we_o),
      .mem_addr_o   (mem_addr_o),
      .beat_o       (beat),
      .spill_done_o (spill_done),
      .fill_we_o    (fill_we),
      .fill_done_o  (fill_done),
      .depth_zero_o (depth_zero)
   );

   logic [N_RD-1:0][4:0]        rd_spec;
   logic [N_RD-1:0][DATA_W-1:0] rd_data;
   assign rd_spec     = {rd_b_spec_i, rd_a_spec_i};
   assign rd_a_data_o = rd_data[0];
   assign rd_b_data_o = rd_data[1];

   for (genvar p = 0; p < N_RD; p++) begin : g_rd
      wrf_read_port #(.DATA_W(DATA_W)) u_rd (
         .spec_i(rd_spec[p]),
         .glob_i(glob_q),
         .outs_i(out_q),
         .locs_i(loc_q),
         .ins_i (in_q),
         .data_o(rd_data[p])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glob_q      <= '0;
         loc_q       <= '0;
         in_q        <= '0;
         out_q       <= '0;
         underflow_q <= 1'b0;
      end else begin
         if (wr_ok) begin
            unique case (spec_group(wr_spec_i))
               GRP_GLOBAL: if (wr_idx != '0) glob_q[wr_idx] <= wr_data_i;
               GRP_OUT:    out_q[wr_idx] <= wr_data_i;
               GRP_LOCAL:  loc_q[wr_idx] <= wr_data_i;
               default:    in_q[wr_idx]  <= wr_data_i;
            endcase
         end
         if (do_save) begin
            in_q  <= out_q;
            loc_q <= '0;
         end else if (do_rest) begin
            out_q <= in_q;
            in_q  <= rest_frame;
            loc_q <= '0;
         end
         if (acc_rest && stk_empty && depth_zero) underflow_q <= 1'b1;
      end
   end

   // R3
   glob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      glob_q[0] == '0);
   // R4
   save_keeps_glob_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_save |=> $stable(glob_q));
   // R10
   underflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rest && stk_empty && depth_zero) |=> underflow_o);
   // R10
   underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underflow_o |=> underflow_o);
   // R9
   busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !spill_done && !fill_done) |=> ($stable(loc_q) && $stable(glob_q)));
endmodule

// File: tb/test_windowed_regfile.sv
`timescale 1ns/1ps
module test_windowed_regfile;
   typedef logic [7:0][31:0] frm_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic save_i = 1'b0, restore_i = 1'b0, wr_en_i = 1'b0;
   logic [4:0] rd_a_spec_i = '0, rd_b_spec_i = '0, wr_spec_i = '0;
   logic [31:0] wr_data_i = '0;
   logic [31:0] rd_a_data_o, rd_b_data_o;
   logic busy_o, underflow_o, mem_req_o, mem_we_o, mem_ack_i = 1'b0;
   logic [11:0] mem_addr_o;
   logic [31:0] mem_wdata_o, mem_rdata_i = '0;

   int n_chk = 0, n_fail = 0, req_cycles = 0;

   // reference model
   frm_t m_glob = '0, m_loc = '0, m_in = '0, m_out = '0;
   frm_t m_stk[$];
   logic [31:0] m_mem[int];
   logic [31:0] b_mem[int];
   int m_fp = 0;
   bit m_uf = 1'b0;

   always #5 clk = ~clk;

   windowed_regfile i_windowed_regfile (
      .clk(clk), .rst_n(rst_n), .save_i(save_i), .restore_i(restore_i),
      .rd_a_spec_i(rd_a_spec_i), .rd_a_data_o(rd_a_data_o),
      .rd_b_spec_i(rd_b_spec_i), .rd_b_data_o(rd_b_data_o),
      .wr_en_i(wr_en_i), .wr_spec_i(wr_spec_i), .wr_data_i(wr_data_i),
      .busy_o(busy_o), .underflow_o(underflow_o),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i)
   );

   // memory responder: acknowledges every other cycle
   always @(negedge clk) begin
      if (mem_req_o && !mem_ack_i) begin
         mem_ack_i = 1'b1;
         if (mem_we_o) b_mem[int'(mem_addr_o)] = mem_wdata_o;
         else mem_rdata_i = b_mem.exists(int'(mem_addr_o)) ? b_mem[int'(mem_addr_o)] : 32'h0;
      end else begin
         mem_ack_i = 1'b0;
      end
   end

   always @(posedge clk) if (rst_n && mem_req_o) req_cycles++;

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(int a);
      case (a / 8)
         0: return m_glob[a % 8];
         1: return m_out[a % 8];
         2: return m_loc[a % 8];
         default: return m_in[a % 8];
      endcase
   endfunction

   task automatic scan(string req);
      for (int a = 0; a < 32; a += 2) begin
         rd_a_spec_i = 5'(a);
         rd_b_spec_i = 5'(a + 1);
         #0.1;
         chk(rd_a_data_o == m_read(a), req, $sformatf("port A reg %0d", a), rd_a_data_o, m_read(a));
         chk(rd_b_data_o == m_read(a + 1), req, $sformatf("port B reg %0d", a + 1), rd_b_data_o, m_read(a + 1));
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      wr_en_i = 1'b1; wr_spec_i = 5'(a); wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
      if (a != 0) begin
         case (a / 8)
            0: m_glob[a % 8] = d;
            1: m_out[a % 8] = d;
            2: m_loc[a % 8] = d;
            default: m_in[a % 8] = d;
         endcase
      end
   endtask

   // model of one accepted command; returns expected busy cycles
   function automatic int m_cmd(bit s, bit r);
      if (s) begin
         int cyc = 0;
         if (m_stk.size() == 4) begin
            frm_t old = m_stk.pop_front();
            for (int k = 0; k < 8; k++) m_mem[m_fp * 8 + k] = old[k];
            m_fp++;
            cyc = 15;
         end
         m_stk.push_back(m_in);
         m_in = m_out; m_loc = '0;
         return cyc;
      end else if (r) begin
         if (m_stk.size() > 0) begin
            m_out = m_in; m_in = m_stk.pop_back(); m_loc = '0;
            return 0;
         end else if (m_fp > 0) begin
            frm_t f;
            m_fp--;
            for (int k = 0; k < 8; k++) f[k] = m_mem[m_fp * 8 + k];
            m_out = m_in; m_in = f; m_loc = '0;
            return 16;
         end else begin
            m_uf = 1'b1;
            return 0;
         end
      end
      return 0;
   endfunction

   task automatic cmd(bit s, bit r, bit wr_too, bit inject, string req);
      int exp_busy;
      save_i = s; restore_i = r;
      if (wr_too) begin wr_en_i = 1'b1; wr_spec_i = 5'd17; wr_data_i = 32'hDEAD_0017; end
      @(negedge clk);
      save_i = 1'b0; restore_i = 1'b0; wr_en_i = 1'b0;
      exp_busy = m_cmd(s, r);
      for (int i = 0; i < exp_busy; i++) begin
         chk(busy_o == 1'b1, "R9", $sformatf("busy at cycle %0d", i), 32'(busy_o), 32'd1);
         if (inject && i == 3) begin
            wr_en_i = 1'b1; wr_spec_i = 5'd18; wr_data_i = 32'hBAD0_0018;
            restore_i = 1'b1;
         end
         @(negedge clk);
         if (inject && i == 3) begin wr_en_i = 1'b0; restore_i = 1'b0; end
      end
      chk(busy_o == 1'b0, (exp_busy == 0) ? req : "R9", "busy low after move", 32'(busy_o), 32'd0);
      scan(req);
      if (exp_busy == 15) begin
         for (int k = 0; k < 8; k++) begin
            int ad = (m_fp - 1) * 8 + k;
            logic [31:0] got = b_mem.exists(ad) ? b_mem[ad] : 32'hxxxx_xxxx;
            chk(got === m_mem[ad], "R7", $sformatf("spilled word at %0d", ad), got, m_mem[ad]);
         end
      end
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      scan("R1");
      chk(busy_o == 1'b0, "R1", "busy after reset", 32'(busy_o), 32'd0);
      chk(underflow_o == 1'b0, "R1", "underflow after reset", 32'(underflow_o), 32'd0);
      chk(mem_req_o == 1'b0, "R1", "mem_req after reset", 32'(mem_req_o), 32'd0);

      // R2 / R3: fill every register, including global 0
      for (int a = 0; a < 32; a++) wr(a, 32'h1000_0000 + 32'(a) * 32'h111);
      scan("R2");
      rd_a_spec_i = 5'd0; #0.1;
      chk(rd_a_data_o == 32'h0, "R3", "global 0 after write", rd_a_data_o, 32'h0);

      // R4 / R5 / R6: shallow nesting
      req_cycles = 0;
      cmd(1'b1, 1'b0, 1'b0, 1'b0, "R4");
      for (int d = 0; d < 2; d++) begin
         for (int k = 0; k < 8; k++) wr(8 + k, 32'h2000_0000 + 32'(d * 16 + k));
         wr(16 + d, 32'h3000_0000 + 32'(d));
         cmd(1'b1, 1'b0, 1'b0, 1'b0, "R4");
      end
      for (int d = 0; d < 3; d++) cmd(1'b0, 1'b1, 1'b0, 1'b0, "R5");
      chk(req_cycles == 0, "R6", "memory requests in shallow nesting", 32'(req_cycles), 32'd0);

      // R7 / R9: fill the stack, then spill
      for (int d = 0; d < 4; d++) begin
         for (int k = 0; k < 8; k++) wr(8 + k, 32'h4000_0000 + 32'(d * 16 + k));
         cmd(1'b1, 1'b0, 1'b0, 1'b0, "R4");
      end
      chk(req_cycles == 0, "R6", "memory requests at depth 4", 32'(req_cycles), 32'd0);
      for (int k = 0; k < 8; k++) wr(8 + k, 32'h5000_0000 + 32'(k));
      cmd(1'b1, 1'b0, 1'b0, 1'b1, "R7");
      for (int k = 0; k < 8; k++) wr(8 + k, 32'h6000_0000 + 32'(k));
      cmd(1'b1, 1'b0, 1'b0, 1'b0, "R7");

      // R11: save and restore together, plus a write, while full
      for (int k = 0; k < 8; k++) wr(8 + k, 32'h7000_0000 + 32'(k));
      cmd(1'b1, 1'b1, 1'b1, 1'b0, "R11");
      // R11 again with a free slot: pop then combined command
      cmd(1'b0, 1'b1, 1'b0, 1'b0, "R5");
      cmd(1'b1, 1'b1, 1'b1, 1'b0, "R11");

      // R5 / R8: drain the stack then fill from memory
      for (int d = 0; d < 4; d++) cmd(1'b0, 1'b1, 1'b0, 1'b0, "R5");
      cmd(1'b0, 1'b1, 1'b0, 1'b1, "R8");
      for (int d = 0; d < 2; d++) cmd(1'b0, 1'b1, 1'b0, 1'b0, "R8");

      // R10: nothing left anywhere
      cmd(1'b0, 1'b1, 1'b0, 1'b0, "R10");
      chk(underflow_o == m_uf, "R10", "underflow flag set", 32'(underflow_o), 32'(m_uf));
      wr(20, 32'h8000_0020);
      cmd(1'b1, 1'b0, 1'b0, 1'b0, "R4");
      chk(underflow_o == 1'b1, "R10", "underflow flag sticky", 32'(underflow_o), 32'd1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule